// File: doc/BRIEF.md
# Vectored Interrupt Byte-Port Controller

This block is a byte-wide peripheral port that a processor reaches through four registers in a small window that starts at a base address. One register holds the last byte received from the device side. One takes a byte to send. One reports and controls status. One holds a programmable interrupt vector. The receive and send paths toward the device are valid/ready byte streams. The status flags change as side effects of processor reads and writes: reading the received byte empties the receive flag, and writing a byte to send empties the send-ready flag until the device side takes the byte.

The block raises an active-high request line, intended to be ORed with the requests of other devices. It does so when an enabled condition is pending: a received byte is waiting, or the port can take a new byte to send. It keeps the request up until it is acknowledged. The acknowledge arrives on a daisy chain. If this port has an unserved request, it takes the acknowledge, places its vector on a dedicated vector bus and blocks the chain. Otherwise it passes the acknowledge on to the next device.

Top module: `vecirq_dev`

## Requirements
- R1: The receive register is at BASE+0, the send register at BASE+2, status at BASE+4 and the vector at BASE+6. A read at any other address, inside or outside the window, returns 0 and changes no state. A write at any other address changes no state.
- R2: A byte accepted on the receive stream sets status bit 0 (receive-full) and can then be read at BASE+0. A read of BASE+0 clears bit 0 at the clock edge that ends the read.
- R3: A byte that arrives while bit 0 is set is dropped, and sticky status bit 7 (overrun) is set. Writing status with bit 7 at 1 clears bit 7. A byte that arrives in the same cycle as a read of BASE+0 is accepted, and overrun is not set.
- R4: Status bit 1 (send-ready) is 1 after reset. A write to BASE+2 while bit 1 is set stores the byte and clears bit 1. It also raises tx_valid with that byte, and holds it until tx_ready is seen. Bit 1 then returns to 1. A write to BASE+2 while bit 1 is clear is ignored.
- R5: Status bits 2 (receive interrupt enable) and 3 (send interrupt enable) are written through BASE+4 and read back there. Status bit 4 (pending) reads as (bit0 AND bit2) OR (bit1 AND bit3).
- R6: irq_req is high while pending is set and has not been acknowledged. Once acknowledged, irq_req stays low until pending has fallen and risen again.
- R7: While ack_in is high and irq_req is high, the block drives vec_valid=1 and vec_data equal to the vector register, and holds ack_out low. Otherwise ack_out follows ack_in, vec_valid is 0 and vec_data is 0.
- R8: The vector register is read and written in full at BASE+6 and resets to RESET_VEC.
- R9: After reset, status reads 0x02, the vector reads RESET_VEC, and irq_req and tx_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from current state |
| rx_valid | input | 1 | Device offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always 1; excess bytes are dropped as overrun |
| tx_valid | output | 1 | A byte is waiting to be sent |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Device takes the byte |
| irq_req | output | 1 | Interrupt request, active high |
| ack_in | input | 1 | Acknowledge from upstream in the chain |
| ack_out | output | 1 | Acknowledge passed downstream |
| vec_valid | output | 1 | This device drives its vector |
| vec_data | output | 8 | Vector value during acknowledge |

## Verification
The bench builds the block with a 16-bit address, base 0x8000 and a reset vector of 0x0F. The non-zero base lets the bench probe an address below the window, an odd offset inside it and the first address past it. It also checks that decoding is relative to the base and not to absolute low addresses. The non-zero reset vector, and the vector values 26 and 64 written later, show that the acknowledge returns the programmed register and not a constant.

// File: rtl/vecirq_pkg.sv
// Shared constants and types for the vectored interrupt byte port.
// Assumes register offsets are even and fit in a 3-bit window.
package vecirq_pkg;
    localparam int OFF_IN   = 0;
    localparam int OFF_OUT  = 2;
    localparam int OFF_STAT = 4;
    localparam int OFF_VEC  = 6;

    localparam int ST_SIN   = 0;
    localparam int ST_SOUT  = 1;
    localparam int ST_IEIN  = 2;
    localparam int ST_IEOUT = 3;
    localparam int ST_PEND  = 4;
    localparam int ST_OVR   = 7;

    typedef struct packed {
        logic rd_in;
        logic wr_out;
        logic rd_stat;
        logic wr_stat;
        logic rd_vec;
        logic wr_vec;
    } bus_hits_t;
endpackage

// File: rtl/vecirq_decode.sv
// Address decoder: turns a processor access into one register strobe.
// Assumes ADDR_W > 3; addresses outside BASE..BASE+7 or at odd or unused
// offsets produce no strobe.
module vecirq_decode
    import vecirq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_hits_t         hits
);
    logic [ADDR_W-1:0] off;
    logic              in_win;

    // Window test and strobe generation.
    always_comb begin
        off    = addr - BASE;
        in_win = sel && (addr >= BASE) && (off[ADDR_W-1:3] == '0);
        hits.rd_in   = in_win && !wr && (off[2:0] == 3'(OFF_IN));
        hits.wr_out  = in_win &&  wr && (off[2:0] == 3'(OFF_OUT));
        hits.rd_stat = in_win && !wr && (off[2:0] == 3'(OFF_STAT));
        hits.wr_stat = in_win &&  wr && (off[2:0] == 3'(OFF_STAT));
        hits.rd_vec  = in_win && !wr && (off[2:0] == 3'(OFF_VEC));
        hits.wr_vec  = in_win &&  wr && (off[2:0] == 3'(OFF_VEC));
    end
endmodule

// File: rtl/vecirq_rx.sv
// Receive holding register with full flag and sticky overrun.
// Assumes the device stream never waits: every offered byte is taken or
// dropped. An arrival in the same cycle as a processor read is kept.
module vecirq_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_in,
    input  logic          ovr_clr,
    output logic          rx_ready,
    output logic          full,
    output logic [DW-1:0] hold,
    output logic          ovr
);
    logic drop;

    assign rx_ready = 1'b1;
    assign drop     = rx_valid && full && !rd_in;

    // Load, empty and overrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            hold <= '0;
            ovr  <= 1'b0;
        end else begin
            if (rx_valid && (!full || rd_in)) begin
                hold <= rx_data;
                full <= 1'b1;
            end else if (rd_in) begin
                full <= 1'b0;
            end
            if (drop)         ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;
        end
    end

    assert_overrun_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full && !rd_in) |=> ($stable(hold) && ovr && full));
    assert_read_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in && !rx_valid) |=> !full);
endmodule

// File: rtl/vecirq_tx.sv
// Send holding register presented as a valid/ready stream.
// Assumes writes while a byte is still waiting are discarded.
module vecirq_tx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_out,
    input  logic [DW-1:0] wdata,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          sout
);
    logic busy;

    assign tx_valid = busy;
    assign sout     = !busy;

    // Capture on write when idle, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tx_data <= '0;
        end else if (busy) begin
            if (tx_ready) busy <= 1'b0;
        end else if (wr_out) begin
            busy    <= 1'b1;
            tx_data <= wdata;
        end
    end

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_tx_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> sout);
endmodule

// File: rtl/vecirq_intr.sv
// Interrupt request generation and daisy-chain acknowledge handling.
// Assumes ack_in is a level held for at least one clock; a served request
// stays quiet until its pending condition drops and returns.
module vecirq_intr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sin,
    input  logic          sout,
    input  logic          ie_in,
    input  logic          ie_out,
    input  logic          ack_in,
    input  logic [DW-1:0] vector,
    output logic          pend,
    output logic          irq_req,
    output logic          ack_out,
    output logic          vec_valid,
    output logic [DW-1:0] vec_data
);
    logic served;
    logic take;

    // Request and chain steering.
    always_comb begin
        pend      = (sin && ie_in) || (sout && ie_out);
        irq_req   = pend && !served;
        take      = ack_in && irq_req;
        ack_out   = ack_in && !take;
        vec_valid = take;
        vec_data  = take ? vector : '0;
    end

    // Remember that the current pending episode was acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)    served <= 1'b0;
        else if (!pend) served <= 1'b0;
        else if (take)  served <= 1'b1;
    end

    assert_ack_quiets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && irq_req) |=> !irq_req);
    assert_chain_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && ack_out));
    assert_chain_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !irq_req) |-> (ack_out && !vec_valid));
endmodule

// File: rtl/vecirq_dev.sv
// Top of the vectored interrupt byte port: register file, read mux and
// wiring of decode, receive, send and interrupt parts.
// Assumes a single-cycle processor access; reads have their side effects
// at the clock edge that ends the access.
module vecirq_dev
    import vecirq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h8000,
    parameter logic [7:0] RESET_VEC = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq_req,
    input  logic              ack_in,
    output logic              ack_out,
    output logic              vec_valid,
    output logic [7:0]        vec_data
);
    localparam int DW = 8;

    bus_hits_t     hits;
    logic          sin, sout, ovr, pend;
    logic [DW-1:0] rx_hold;
    logic          ie_in, ie_out;
    logic [DW-1:0] vec_q;
    logic [DW-1:0] status;

    vecirq_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .sel(cpu_sel), .wr(cpu_wr), .addr(cpu_addr), .hits(hits)
    );

    vecirq_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_in(hits.rd_in), .ovr_clr(hits.wr_stat && cpu_wdata[ST_OVR]),
        .rx_ready(rx_ready), .full(sin), .hold(rx_hold), .ovr(ovr)
    );

    vecirq_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_out(hits.wr_out), .wdata(cpu_wdata),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .sout(sout)
    );

    vecirq_intr #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .sin(sin), .sout(sout), .ie_in(ie_in),
        .ie_out(ie_out), .ack_in(ack_in), .vector(vec_q), .pend(pend),
        .irq_req(irq_req), .ack_out(ack_out), .vec_valid(vec_valid),
        .vec_data(vec_data)
    );

    // Enable bits and vector register, written by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_in  <= 1'b0;
            ie_out <= 1'b0;
            vec_q  <= RESET_VEC;
        end else begin
            if (hits.wr_stat) begin
                ie_in  <= cpu_wdata[ST_IEIN];
                ie_out <= cpu_wdata[ST_IEOUT];
            end
            if (hits.wr_vec) vec_q <= cpu_wdata;
        end
    end

    // Status byte assembly.
    always_comb begin
        status           = '0;
        status[ST_SIN]   = sin;
        status[ST_SOUT]  = sout;
        status[ST_IEIN]  = ie_in;
        status[ST_IEOUT] = ie_out;
        status[ST_PEND]  = pend;
        status[ST_OVR]   = ovr;
    end

    // Read data mux; unmapped reads return zero.
    always_comb begin
        cpu_rdata = '0;
        if (hits.rd_in)   cpu_rdata = rx_hold;
        if (hits.rd_stat) cpu_rdata = status;
        if (hits.rd_vec)  cpu_rdata = vec_q;
    end

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));
    assert_vector_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hits.wr_vec |=> (vec_q == $past(cpu_wdata)));
endmodule

// File: tb/vecirq_dev_test.sv
// Directed bench for vecirq_dev: one task per scenario.
module vecirq_dev_test;
    localparam logic [15:0] BASE = 16'h8000;
    localparam logic [7:0]  RV   = 8'h0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        irq_req, ack_in = 1'b0, ack_out, vec_valid;
    logic [7:0]  vec_data;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    vecirq_dev #(.ADDR_W(16), .BASE(BASE), .RESET_VEC(RV)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq_req(irq_req), .ack_in(ack_in), .ack_out(ack_out),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(BASE + 4, d); chk("R9 status", d, 8'h02);
        rd(BASE + 6, d); chk("R9 vector", d, RV);
        chk("R9 irq", irq_req, 0);
        chk("R9 tx_valid", tx_valid, 0);
        chk("R9 rx_ready", rx_ready, 1);
        @(negedge clk); ack_in = 1'b1; #1;
        chk("R7 pass ack_out", ack_out, 1);
        chk("R7 pass vec_valid", vec_valid, 0);
        @(negedge clk); ack_in = 1'b0;
    endtask

    task automatic t_rx();
        logic [7:0] d;
        push(8'hA5);
        rd(BASE + 4, d); chk("R2 full set", d, 8'h03);
        rd(BASE + 0, d); chk("R2 data", d, 8'hA5);
        rd(BASE + 4, d); chk("R2 cleared by read", d, 8'h02);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        push(8'h11);
        push(8'h22);
        rd(BASE + 4, d); chk("R3 overrun flag", d, 8'h83);
        rd(BASE + 0, d); chk("R3 first byte kept", d, 8'h11);
        wr(BASE + 4, 8'h80);
        rd(BASE + 4, d); chk("R3 overrun cleared", d, 8'h02);
        push(8'h33);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = BASE;
        rx_valid = 1'b1; rx_data = 8'h44;
        #1 chk("R3 read during arrival", cpu_rdata, 8'h33);
        @(negedge clk);
        cpu_sel = 1'b0; rx_valid = 1'b0;
        rd(BASE + 4, d); chk("R3 same-cycle accept", d, 8'h03);
        rd(BASE + 0, d); chk("R3 new byte", d, 8'h44);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        tx_ready = 1'b0;
        wr(BASE + 2, 8'h5A);
        rd(BASE + 4, d); chk("R4 send-ready clear", d, 8'h00);
        chk("R4 tx_valid", tx_valid, 1);
        chk("R4 tx_data", tx_data, 8'h5A);
        wr(BASE + 2, 8'h77);
        chk("R4 busy write ignored", tx_data, 8'h5A);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R4 tx_valid dropped", tx_valid, 0);
        rd(BASE + 4, d); chk("R4 send-ready back", d, 8'h02);
    endtask

    task automatic t_vec();
        logic [7:0] d;
        wr(BASE + 6, 8'd26);
        rd(BASE + 6, d); chk("R8 vector 26", d, 26);
        wr(BASE + 6, 8'd64);
        rd(BASE + 6, d); chk("R8 vector 64", d, 64);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        push(8'h9C);
        rd(BASE + 1, d); chk("R1 odd offset", d, 0);
        rd(BASE + 8, d); chk("R1 past window", d, 0);
        rd(16'h0000, d); chk("R1 below base", d, 0);
        rd(BASE + 4, d); chk("R1 no side effect", d, 8'h03);
        wr(BASE + 3, 8'hFF);
        wr(BASE + 5, 8'hFF);
        rd(BASE + 4, d); chk("R1 stray write", d, 8'h03);
        rd(BASE + 6, d); chk("R1 vector intact", d, 64);
        rd(BASE + 0, d); chk("R1 map input", d, 8'h9C);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(BASE + 4, 8'h04);
        chk("R5 no pending", irq_req, 0);
        rd(BASE + 4, d); chk("R5 enable readback", d, 8'h06);
        push(8'h01);
        chk("R6 request up", irq_req, 1);
        rd(BASE + 4, d); chk("R5 pending bit", d, 8'h17);
        @(negedge clk); ack_in = 1'b1; #1;
        chk("R7 vec_valid", vec_valid, 1);
        chk("R7 vec_data", vec_data, 64);
        chk("R7 chain blocked", ack_out, 0);
        @(negedge clk); ack_in = 1'b0;
        chk("R6 quiet after ack", irq_req, 0);
        @(negedge clk); ack_in = 1'b1; #1;
        chk("R7 pass after ack", ack_out, 1);
        @(negedge clk); ack_in = 1'b0;
        rd(BASE + 4, d); chk("R6 still pending", d, 8'h17);
        rd(BASE + 0, d);
        push(8'h02);
        chk("R6 re-raised", irq_req, 1);
        rd(BASE + 0, d);
        chk("R6 drops with source", irq_req, 0);
        wr(BASE + 4, 8'h08);
        chk("R5 send enable", irq_req, 1);
        rd(BASE + 4, d); chk("R5 send pending", d, 8'h1A);
        wr(BASE + 4, 8'h00);
        chk("R5 disabled", irq_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx();
        t_overrun();
        t_tx();
        t_vec();
        t_unmapped();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule